// File: doc/BRIEF.md
# Multi-Set Doorbell Interrupt Controller

This block lets software on any core of a 17-core cluster interrupt any other core. The cluster has sixteen processing elements and one resource-manager core. The block holds eight doorbell sets. Each set has a trigger register and a per-core enable mask. Writing a trigger register latches pending bits for the selected cores in that set. A core's interrupt line is raised while any set holds a pending bit for that core with the matching enable bit set.

A receiving core clears its pending bits by writing ones to the set's acknowledge alias. Pending state survives a mask change, so disabling a core's delivery does not lose the doorbell.

Access uses a simple synchronous register bus: one request per cycle, with read data returned the following cycle.

Top module: `ipi_doorbell_ctrl`

## Requirements
- R1: After reset every pending bit and every mask bit is 0, `irq_o` is all zero, and all registers read as zero.
- R2: A write to byte offset 8*s (set s trigger) ORs `wdata_i[16:0]` into the pending vector of set s. Zero bits leave pending bits unchanged, and `wdata_i[31:17]` is ignored. A read of offset 8*s returns the pending vector of set s.
- R3: A write to byte offset 8*s+4 stores `wdata_i[16:0]` as the mask of set s. A read of that offset returns the stored mask.
- R4: `irq_o[k]` is 1 exactly when some set s has both pending bit k and mask bit k set. Bit k for k in 0..15 drives processing element k, and bit 16 drives the resource-manager core. A register write shows on `irq_o` in the cycle after the clock edge that accepts it.
- R5: Clearing a mask bit drops the interrupt line while the pending bit is kept.
- R6: A read accepted at one clock edge presents its data on `rdata_o` after that edge, until the next edge. Bits 31:17 are always 0. In cycles not following an accepted read, `rdata_o` is 0.
- R7: A write to byte offset 0x40+8*s (acknowledge alias of set s) clears each pending bit of set s whose `wdata_i` bit is 1. If a trigger and an acknowledge hit the same bit in the same cycle, the bit ends set.
- R8: Accesses with `addr_i[1:0]` not 0 are unmapped. So are offsets 0x44+8*s and offsets at or above 0x80. Reads of the acknowledge aliases and of any unmapped offset return 0. Writes to unmapped offsets change no state.
- R9: A write to one set changes the pending and mask state of no other set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle after a read request |
| irq_o | output | 17 | Level interrupt per core; bit 16 is the resource-manager core |

## Verification
A wrong pending bit shows as a wrong `irq_o` bit as soon as the mask for that core is set, one cycle after the write that caused it. It also shows on `rdata_o` one cycle after the set's trigger register is read. A wrong mask bit shows the same way, through the mask readback and through the interrupt lines.

The bench compares both outputs against a behavioural model on every cycle. A corrupted state is therefore reported no later than the next read of that set, or the first cycle that exposes it on `irq_o`. Set independence and the unmapped offsets are checked by reading back every set after the stray writes.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned NUM_SETS  = 8;
  localparam int unsigned NUM_CORES = 17;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 32;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_TRIG = 2'd1,
    ACC_MASK = 2'd2,
    ACC_ACK  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec
  import ipi_pkg::*;
#(
  parameter int unsigned N_SETS = NUM_SETS,
  parameter int unsigned A_W    = ADDR_W,
  localparam int unsigned SET_W = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
  input  logic [A_W-1:0]   addr_i,
  output acc_kind_e        kind_o,
  output logic [SET_W-1:0] set_o
);
  localparam int unsigned REG_WORDS = 2 * N_SETS;  // trigger+mask words
  localparam int unsigned WORD_W    = A_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr_i[A_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    kind_o = ACC_NONE;
    set_o  = '0;
    if (aligned) begin
      if (int'(word) < REG_WORDS) begin
        kind_o = word[0] ? ACC_MASK : ACC_TRIG;
        set_o  = SET_W'(word >> 1);
      end else if (int'(word) < 2 * REG_WORDS && !word[0]) begin
        // ack alias sits one register block above the trigger registers
        kind_o = ACC_ACK;
        set_o  = SET_W'((int'(word) - REG_WORDS) >> 1);
      end
    end
  end
endmodule

// File: rtl/ipi_set.sv
module ipi_set #(
  parameter int unsigned N_CORES = ipi_pkg::NUM_CORES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_we_i,
  input  logic               mask_we_i,
  input  logic               ack_we_i,
  input  logic [N_CORES-1:0] bits_i,
  output logic [N_CORES-1:0] pend_o,
  output logic [N_CORES-1:0] mask_o
);
  logic [N_CORES-1:0] pend_q, pend_d, mask_q;
  logic [N_CORES-1:0] set_bits, clr_bits;

  assign set_bits = trig_we_i ? bits_i : '0;
  assign clr_bits = ack_we_i  ? bits_i : '0;
  // trigger dominates acknowledge on the same bit
  assign pend_d   = (pend_q & ~clr_bits) | set_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (mask_we_i) mask_q <= bits_i;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;

  AST_TRIG_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_we_i |=> ((pend_q & $past(bits_i)) == $past(bits_i)));  // R2
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && !trig_we_i) |=> ((pend_q & $past(bits_i)) == '0));  // R7
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_we_i && !ack_we_i) |=> $stable(pend_q));  // R9
  AST_MASK_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_q == $past(bits_i)));  // R3
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));  // R5
endmodule

// File: rtl/ipi_irq_merge.sv
module ipi_irq_merge #(
  parameter int unsigned N_SETS  = ipi_pkg::NUM_SETS,
  parameter int unsigned N_CORES = ipi_pkg::NUM_CORES
) (
  input  logic [N_SETS-1:0][N_CORES-1:0] pend_i,
  input  logic [N_SETS-1:0][N_CORES-1:0] mask_i,
  output logic [N_CORES-1:0]             irq_o
);
  logic [N_SETS-1:0][N_CORES-1:0] live;

  for (genvar s = 0; s < N_SETS; s++) begin : g_live
    assign live[s] = pend_i[s] & mask_i[s];
  end

  always_comb begin
    irq_o = '0;
    for (int s = 0; s < N_SETS; s++) irq_o |= live[s];
  end
endmodule

// File: rtl/ipi_doorbell_ctrl.sv
module ipi_doorbell_ctrl
  import ipi_pkg::*;
#(
  parameter int unsigned N_SETS  = NUM_SETS,
  parameter int unsigned N_CORES = NUM_CORES,
  parameter int unsigned A_W     = ADDR_W,
  parameter int unsigned D_W     = DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [A_W-1:0]     addr_i,
  input  logic [D_W-1:0]     wdata_i,
  output logic [D_W-1:0]     rdata_o,
  output logic [N_CORES-1:0] irq_o
);
  localparam int unsigned SET_W = (N_SETS > 1) ? $clog2(N_SETS) : 1;

  acc_kind_e                      kind;
  logic [SET_W-1:0]               set_sel;
  logic [N_CORES-1:0]             bits;
  logic [N_SETS-1:0][N_CORES-1:0] pend, mask;
  logic [D_W-1:0]                 rd_val, rdata_q;
  logic                           wr, rd;
  logic                           unused_wdata_hi;

  assign bits            = wdata_i[N_CORES-1:0];
  assign unused_wdata_hi = ^wdata_i[D_W-1:N_CORES];
  assign wr              = req_i && we_i;
  assign rd              = req_i && !we_i;

  ipi_addr_dec #(.N_SETS(N_SETS), .A_W(A_W)) dec_i (
    .addr_i (addr_i),
    .kind_o (kind),
    .set_o  (set_sel)
  );

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    logic hit;
    assign hit = wr && (int'(set_sel) == s);
    ipi_set #(.N_CORES(N_CORES)) set_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .trig_we_i (hit && kind == ACC_TRIG),
      .mask_we_i (hit && kind == ACC_MASK),
      .ack_we_i  (hit && kind == ACC_ACK),
      .bits_i    (bits),
      .pend_o    (pend[s]),
      .mask_o    (mask[s])
    );
  end

  ipi_irq_merge #(.N_SETS(N_SETS), .N_CORES(N_CORES)) merge_i (
    .pend_i (pend),
    .mask_i (mask),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_val = '0;
    unique case (kind)
      ACC_TRIG: rd_val[N_CORES-1:0] = pend[set_sel];
      ACC_MASK: rd_val[N_CORES-1:0] = mask[set_sel];
      default:  rd_val = '0;  // ack alias and holes read zero
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd ? rd_val : '0;
  end

  assign rdata_o = rdata_q;

  AST_RDATA_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[D_W-1:N_CORES] == '0);  // R6
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> (rdata_o == '0));  // R6
  AST_HOLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (kind == ACC_NONE || kind == ACC_ACK)) |=> (rdata_o == '0));  // R8
  AST_HOLE_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && kind == ACC_NONE) |=> ($stable(pend) && $stable(mask)));  // R8
  AST_IDLE_IRQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(irq_o));  // R4
endmodule

// File: tb/ipi_doorbell_ctrl_tb_top.sv
module ipi_doorbell_ctrl_tb_top;
  localparam int NS = 8;
  localparam int NC = 17;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [16:0] irq;

  always #4 clk = ~clk;  // 125 MHz

  ipi_doorbell_ctrl dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  logic [16:0] m_pend [NS];
  logic [16:0] m_mask [NS];
  logic [31:0] exp_rd;
  string       rd_tag;
  string       phase;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  function automatic logic [16:0] model_irq();
    logic [16:0] v = '0;
    for (int s = 0; s < NS; s++) v |= m_pend[s] & m_mask[s];
    return v;
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", phase, tag, act, exp, $time);
    end
  endtask

  // compare outputs of the previous edge, then present the next access
  task automatic step(input logic r, input logic w, input logic [7:0] a, input logic [31:0] d);
    int word;
    @(negedge clk);
    cmp("R4 irq", {15'b0, irq}, {15'b0, model_irq()});
    cmp(rd_tag, rdata, exp_rd);
    exp_rd = '0;
    rd_tag = "R6 idle rdata";
    word   = int'(a >> 2);
    if (r && !w) begin
      rd_tag = "R8 hole read";
      if (a[1:0] == 2'b00 && word < 2 * NS) begin
        if (word % 2 == 0) begin
          exp_rd = {15'b0, m_pend[word / 2]}; rd_tag = "R2 R6 trigger read";
        end else begin
          exp_rd = {15'b0, m_mask[word / 2]}; rd_tag = "R3 R6 mask read";
        end
      end
    end else if (r && w && a[1:0] == 2'b00) begin
      if (word < 2 * NS) begin
        if (word % 2 == 0) m_pend[word / 2] |= d[16:0];
        else               m_mask[word / 2]  = d[16:0];
      end else if (word < 4 * NS && word % 2 == 0) begin
        m_pend[(word - 2 * NS) / 2] &= ~d[16:0];
      end
    end
    req = r; we = w; addr = a; wdata = d;
  endtask

  task automatic rd_all();
    for (int s = 0; s < NS; s++) begin
      step(1, 0, 8'(8 * s), '0);
      step(1, 0, 8'(8 * s + 4), '0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin m_pend[s] = '0; m_mask[s] = '0; end
    exp_rd = '0; rd_tag = "R1 reset rdata"; phase = "R1";
    req = 0; we = 0; addr = '0; wdata = '0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: everything reads zero out of reset
    rd_all();

    phase = "R2";  // OR accumulation, upper data bits ignored
    step(1, 1, 8'h10, 32'hFFFE_0003);
    step(1, 1, 8'h10, 32'h0001_0004);
    step(1, 1, 8'h10, 32'h0000_0000);
    step(1, 0, 8'h10, '0);

    phase = "R3";
    step(1, 1, 8'h14, 32'hFFFF_FFFF);
    step(1, 0, 8'h14, '0);
    step(1, 1, 8'h3C, 32'h0001_0000);  // resource-manager enable in set 7
    step(1, 1, 8'h38, 32'h0001_0000);

    phase = "R5";  // mask off: line drops, pending kept
    step(1, 1, 8'h14, 32'h0);
    step(1, 0, 8'h10, '0);
    step(1, 1, 8'h14, 32'h0001_FFFF);

    phase = "R7";
    step(1, 1, 8'h50, 32'h0000_0003);
    step(1, 0, 8'h10, '0);
    step(1, 1, 8'h78, 32'h0001_0000);
    step(1, 0, 8'h38, '0);

    phase = "R8";
    step(1, 1, 8'h84, 32'h0001_FFFF);
    step(1, 1, 8'h11, 32'h0001_FFFF);
    step(1, 1, 8'h54, 32'h0001_FFFF);
    step(1, 1, 8'hFC, 32'h0001_FFFF);
    step(1, 0, 8'h50, '0);
    step(1, 0, 8'h13, '0);
    step(1, 0, 8'hF0, '0);
    rd_all();

    phase = "R9";
    step(1, 1, 8'h28, 32'h0000_0200);
    step(1, 1, 8'h04, 32'h0000_0200);
    step(1, 1, 8'h2C, 32'h0000_0200);
    rd_all();

    phase = "R4";
    for (int i = 0; i < 4000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int          pick;
      pick = int'($urandom_range(0, 19));
      a    = 8'($urandom_range(0, 31) * 4);
      if (pick == 19) a = 8'($urandom_range(0, 255));
      d    = $urandom & ((pick % 3 == 0) ? 32'hFFFF_FFFF : (32'h1 << $urandom_range(0, 16)));
      step(pick < 17, pick > 8, a, d);
    end
    rd_all();

    step(0, 0, '0, '0);
    step(0, 0, '0, '0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule